// File: doc/BRIEF.md
# Static Memory Bus Turnaround Inserter

This block sits between a transfer sequencer and the external static memory pins of a memory controller. It decides how many idle clock cycles must pass between the end of one external transfer and the start of the next. It keeps a record of the last transfer it granted: its direction, whether it was synchronous or asynchronous, and its bank. When a new request is pending, it combines that record with the request's own attributes and the settings of the bank that did the last transfer, and from these it works out the gap the request needs.

The gap is not always the programmed per-bank value. A write followed by a synchronous transfer uses fixed gaps of two or three cycles. Two asynchronous writes to the same bank need no gap, unless that bank is multiplexed or runs in access mode D. A read leaves no gap behind it. The block counts idle cycles from the cycle in which the sequencer reports the end of a transfer. It grants a waiting request once enough idle cycles have passed. Cycles spent idle before the request shows up count toward the gap.

Each bank holds a 4-bit turnaround value, a 2-bit access mode, an extended-mode enable and a multiplexed flag. These settings are loaded through a one-cycle configuration write strobe.

Top module: `turngap_top`

## Requirements
- R1: After reset, every bank holds turnaround value 15, access mode A (00), extended mode off and multiplexed off.
- R2: A cycle with cfgWrEn high loads cfgGap, cfgMode, cfgExt and cfgMux into the bank selected by cfgBank. The new values take effect from the following cycle.
- R3: grant is high for exactly one cycle per transfer, and only while reqValid is high, busy is low and the needed gap has elapsed. busy rises in the cycle after grant and falls in the cycle after xferDone. xferDone while busy is low is ignored.
- R4: With a needed gap of N, and the request held from the cycle after xferDone, grant arrives exactly N cycles after that first request cycle. Idle cycles before the request count toward N.
- R5: After reset, and after a granted read, the next request is granted with no gap.
- R6: After an asynchronous write, any following transfer needs the turnaround value of the bank that did that write, except in the case R7 exempts.
- R7: After an asynchronous write, an asynchronous write to the same bank needs no gap. This exemption does not apply when that bank is multiplexed, or when its extended mode is on and its access mode is D (11); the programmed value is then needed.
- R8: Access mode D has no effect while extended mode is off, and modes A, B and C never remove the same-bank exemption.
- R9: After a synchronous write, a synchronous write to the same bank needs 2 cycles.
- R10: After a synchronous write, a synchronous write to another bank, or a synchronous read from any bank, needs 3 cycles.
- R11: After a synchronous write, an asynchronous read or write to any bank needs 2 cycles.
- R12: The settings used for the gap are the ones held in the cycle being evaluated. A configuration write during a wait changes the need from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgBank | input | 2 | Bank selected for the configuration write |
| cfgGap | input | 4 | Turnaround value to load (0..15) |
| cfgMode | input | 2 | Access mode to load (00 A, 01 B, 10 C, 11 D) |
| cfgExt | input | 1 | Extended-mode enable to load |
| cfgMux | input | 1 | Multiplexed-bank flag to load |
| reqValid | input | 1 | Pending transfer request, held until granted |
| reqWrite | input | 1 | Pending transfer is a write (1) or a read (0) |
| reqSync | input | 1 | Pending transfer is synchronous (1) or asynchronous (0) |
| reqBank | input | 2 | Bank of the pending transfer |
| xferDone | input | 1 | Last cycle of the granted transfer |
| grant | output | 1 | Pending request may start this cycle |
| busy | output | 1 | A granted transfer has not yet finished |

## Verification
A configuration write and a grant decision can fall in the same cycle, and the grant must still use the old settings in that cycle. The bench provokes this by writing a smaller turnaround value to the bank whose asynchronous write is being waited on, while a read is already pending. The behavioural model then expects the grant to be withheld in the write cycle and to arrive in the first cycle in which the idle count meets the new value. A second collision, a stray xferDone while no transfer is running, is placed just before a request and judged by the request being granted at once.

// File: rtl/turngap_pkg.sv
package turngap_pkg;

  // Strobes from control to datapath, one cycle wide each.
  typedef struct packed {
    logic grantStb;   // a request is granted: capture its attributes
    logic doneStb;    // the running transfer ends: restart the idle count
  } gapStrobe_t;

  typedef enum logic [1:0] {
    MODE_A = 2'b00,
    MODE_B = 2'b01,
    MODE_C = 2'b10,
    MODE_D = 2'b11
  } accMode_t;

endpackage

// File: rtl/turngap_ctrl.sv
module turngap_ctrl
  import turngap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       xferDone,
  input  logic       gapMet,
  output logic       grant,
  output logic       busy,
  output gapStrobe_t stb
);

  logic busyQ;

  // A request wins only on an idle bus whose gap has elapsed.
  always_comb begin
    grant        = reqValid && !busyQ && gapMet;
    stb.grantStb = grant;
    stb.doneStb  = xferDone && busyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (stb.grantStb) begin
      busyQ <= 1'b1;
    end else if (stb.doneStb) begin
      busyQ <= 1'b0;
    end
  end

  assign busy = busyQ;

endmodule

// File: rtl/turngap_dp.sv
module turngap_dp
  import turngap_pkg::*;
#(
  parameter int NUM_BANKS      = 4,
  parameter int GAP_W          = 4,
  parameter int SYNC_SAME_GAP  = 2,
  parameter int SYNC_CROSS_GAP = 3,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [BANK_W-1:0] cfgBank,
  input  logic [GAP_W-1:0]  cfgGap,
  input  logic [1:0]        cfgMode,
  input  logic              cfgExt,
  input  logic              cfgMux,
  input  logic              reqWrite,
  input  logic              reqSync,
  input  logic [BANK_W-1:0] reqBank,
  input  gapStrobe_t        stb,
  output logic              gapMet
);

  localparam logic [GAP_W-1:0] FIX_NEAR = GAP_W'(SYNC_SAME_GAP);
  localparam logic [GAP_W-1:0] FIX_FAR  = GAP_W'(SYNC_CROSS_GAP);
  localparam logic [GAP_W-1:0] GAP_MAX  = '1;

  // Per-bank settings.
  logic [GAP_W-1:0] gapReg  [NUM_BANKS];
  accMode_t         modeReg [NUM_BANKS];
  logic             extReg  [NUM_BANKS];
  logic             muxReg  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        gapReg[b]  <= GAP_MAX;
        modeReg[b] <= MODE_A;
        extReg[b]  <= 1'b0;
        muxReg[b]  <= 1'b0;
      end else if (cfgWrEn && (cfgBank == BANK_W'(b))) begin
        gapReg[b]  <= cfgGap;
        modeReg[b] <= accMode_t'(cfgMode);
        extReg[b]  <= cfgExt;
        muxReg[b]  <= cfgMux;
      end
    end
  end

  // Record of the last granted transfer.
  logic              prevValid;
  logic              prevWrite;
  logic              prevSync;
  logic [BANK_W-1:0] prevBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevWrite <= 1'b0;
      prevSync  <= 1'b0;
      prevBank  <= '0;
    end else if (stb.grantStb) begin
      prevValid <= 1'b1;
      prevWrite <= reqWrite;
      prevSync  <= reqSync;
      prevBank  <= reqBank;
    end
  end

  // Idle cycles since the last transfer ended, saturating.
  logic [GAP_W-1:0] idleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= GAP_MAX;
    end else if (stb.doneStb) begin
      idleCnt <= '0;
    end else if (idleCnt != GAP_MAX) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // Settings of the bank that did the last transfer, read live.
  logic [GAP_W-1:0] selGap;
  logic             selStrict;
  logic             sameBank;

  always_comb begin
    selGap    = gapReg[prevBank];
    selStrict = muxReg[prevBank] || (extReg[prevBank] && (modeReg[prevBank] == MODE_D));
    sameBank  = (reqBank == prevBank);
  end

  logic [GAP_W-1:0] needGap;

  always_comb begin
    needGap = '0;
    if (prevValid && prevWrite) begin
      if (prevSync) begin
        if (!reqSync) begin
          needGap = FIX_NEAR;
        end else if (reqWrite && sameBank) begin
          needGap = FIX_NEAR;
        end else begin
          needGap = FIX_FAR;
        end
      end else begin
        if (reqWrite && !reqSync && sameBank && !selStrict) begin
          needGap = '0;
        end else begin
          needGap = selGap;
        end
      end
    end
  end

  assign gapMet = (idleCnt >= needGap);

endmodule

// File: rtl/turngap_top.sv
module turngap_top
  import turngap_pkg::*;
#(
  parameter int NUM_BANKS      = 4,
  parameter int GAP_W          = 4,
  parameter int SYNC_SAME_GAP  = 2,
  parameter int SYNC_CROSS_GAP = 3,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [BANK_W-1:0] cfgBank,
  input  logic [GAP_W-1:0]  cfgGap,
  input  logic [1:0]        cfgMode,
  input  logic              cfgExt,
  input  logic              cfgMux,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSync,
  input  logic [BANK_W-1:0] reqBank,
  input  logic              xferDone,
  output logic              grant,
  output logic              busy
);

  gapStrobe_t stb;
  logic       gapMet;

  turngap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .xferDone (xferDone),
    .gapMet   (gapMet),
    .grant    (grant),
    .busy     (busy),
    .stb      (stb)
  );

  turngap_dp #(
    .NUM_BANKS      (NUM_BANKS),
    .GAP_W          (GAP_W),
    .SYNC_SAME_GAP  (SYNC_SAME_GAP),
    .SYNC_CROSS_GAP (SYNC_CROSS_GAP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgBank  (cfgBank),
    .cfgGap   (cfgGap),
    .cfgMode  (cfgMode),
    .cfgExt   (cfgExt),
    .cfgMux   (cfgMux),
    .reqWrite (reqWrite),
    .reqSync  (reqSync),
    .reqBank  (reqBank),
    .stb      (stb),
    .gapMet   (gapMet)
  );

endmodule

// File: rtl/turngap_chk.sv
module turngap_chk #(
  parameter int NUM_BANKS = 4,
  parameter int GAP_W     = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqSync,
  input logic [BANK_W-1:0] reqBank,
  input logic              xferDone,
  input logic              grant,
  input logic              busy
);

  // Independent tracking of the last grant and the idle cycles since its end.
  logic              lastWr;
  logic              lastSyncWr;
  logic [BANK_W-1:0] lastBank;
  logic [GAP_W-1:0]  idleSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastWr     <= 1'b0;
      lastSyncWr <= 1'b0;
      lastBank   <= '0;
      idleSeen   <= '1;
    end else begin
      if (grant) begin
        lastWr     <= reqWrite;
        lastSyncWr <= reqWrite && reqSync;
        lastBank   <= reqBank;
      end
      if (busy && xferDone) begin
        idleSeen <= '0;
      end else if (idleSeen != '1) begin
        idleSeen <= idleSeen + 1'b1;
      end
    end
  end

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> reqValid); // R3
  AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !grant); // R3
  AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    grant |=> busy); // R3
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && xferDone) |=> !busy); // R3
  AST_STRAY_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !grant) |=> !busy); // R3
  AST_READ_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !lastWr) |-> grant); // R5
  AST_SYNC_NEAR_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (grant && lastSyncWr) |-> (idleSeen >= GAP_W'(2))); // R9
  AST_SYNC_FAR_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (grant && lastSyncWr && reqSync && (!reqWrite || (reqBank != lastBank)))
      |-> (idleSeen >= GAP_W'(3))); // R10

endmodule

bind turngap_top turngap_chk #(
  .NUM_BANKS (NUM_BANKS),
  .GAP_W     (GAP_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqSync  (reqSync),
  .reqBank  (reqBank),
  .xferDone (xferDone),
  .grant    (grant),
  .busy     (busy)
);

// File: tb/turngap_top_tb.sv
`timescale 1ns/1ps
module turngap_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [1:0] cfgBank = '0;
  logic [3:0] cfgGap = '0;
  logic [1:0] cfgMode = '0;
  logic       cfgExt = 1'b0;
  logic       cfgMux = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqWrite = 1'b0;
  logic       reqSync = 1'b0;
  logic [1:0] reqBank = '0;
  logic       xferDone = 1'b0;
  logic       grant;
  logic       busy;

  always #2.5 clk = ~clk;

  turngap_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgBank(cfgBank),
    .cfgGap(cfgGap), .cfgMode(cfgMode), .cfgExt(cfgExt), .cfgMux(cfgMux),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSync(reqSync),
    .reqBank(reqBank), .xferDone(xferDone), .grant(grant), .busy(busy)
  );

  int testCnt = 0;
  int failCnt = 0;

  // Behavioural reference model.
  int mGap [4];
  int mMode[4];
  int mExt [4];
  int mMux [4];
  int mValid, mWrite, mSync, mBank, mBusy, mIdle;
  logic lastGrant;

  function automatic int modelNeed();
    if (mValid == 0 || mWrite == 0) return 0;
    if (mSync != 0) begin
      if (!reqSync) return 2;                          // R11
      if (reqWrite && int'(reqBank) == mBank) return 2; // R9
      return 3;                                        // R10
    end
    if (reqWrite && !reqSync && int'(reqBank) == mBank &&
        mMux[mBank] == 0 && !(mExt[mBank] != 0 && mMode[mBank] == 3))
      return 0;                                        // R7
    return mGap[mBank];                                // R6
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int b = 0; b < 4; b++) begin
      mGap[b] = 15; mMode[b] = 0; mExt[b] = 0; mMux[b] = 0;
    end
    mValid = 0; mWrite = 0; mSync = 0; mBank = 0; mBusy = 0; mIdle = 15;
  endtask

  // One clock: compare at mid-cycle, then advance the model over the edge.
  task automatic step();
    bit expGrant;
    int oldBusy;
    #1;
    expGrant = reqValid && (mBusy == 0) && (mIdle >= modelNeed());
    check(grant == expGrant, "R4 grant cycle", int'(grant), int'(expGrant));
    check(busy == (mBusy != 0), "R3 busy", int'(busy), mBusy);
    lastGrant = grant;
    @(posedge clk);
    oldBusy = mBusy;
    if (cfgWrEn) begin
      mGap[cfgBank] = cfgGap; mMode[cfgBank] = cfgMode;
      mExt[cfgBank] = cfgExt; mMux[cfgBank] = cfgMux;
    end
    if (expGrant) begin
      mBusy = 1; mValid = 1; mWrite = reqWrite; mSync = reqSync; mBank = reqBank;
    end else if (xferDone && oldBusy != 0) begin
      mBusy = 0;
    end
    if (xferDone && oldBusy != 0) mIdle = 0;
    else if (mIdle < 15) mIdle++;
    @(negedge clk);
  endtask

  task automatic cfgWrite(input int b, input int g, input int m, input int e, input int x);
    cfgBank = 2'(b); cfgGap = 4'(g); cfgMode = 2'(m); cfgExt = 1'(e); cfgMux = 1'(x);
    cfgWrEn = 1'b1;
    step();
    cfgWrEn = 1'b0;
  endtask

  // Request, wait for grant, one busy cycle, then the done cycle.
  // cfgAt >= 0 raises cfgWrEn (fields preset by caller) at that wait index.
  task automatic xfer(input bit w, input bit s, input int b, input int expWait,
                      input int cfgAt, input string req);
    int waited = 0;
    bit seen = 0;
    reqValid = 1'b1; reqWrite = w; reqSync = s; reqBank = 2'(b);
    while (!seen && waited <= 40) begin
      if (waited == cfgAt) cfgWrEn = 1'b1;
      step();
      cfgWrEn = 1'b0;
      if (lastGrant) seen = 1; else waited++;
    end
    reqValid = 1'b0;
    step();
    xferDone = 1'b1;
    step();
    xferDone = 1'b0;
    check(waited == expWait, req, waited, expWait);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(grant == 1'b0, "R3 reset grant", int'(grant), 0);
    check(busy == 1'b0, "R3 reset busy", int'(busy), 0);
    rstN = 1'b1;

    cfgWrite(2, 5, 0, 0, 0);                    // R2
    cfgWrite(1, 7, 0, 0, 0);                    // R2
    xfer(0, 0, 0, 0, -1, "R5 first transfer");
    xfer(0, 0, 1, 0, -1, "R5 after read");
    xfer(1, 0, 0, 0, -1, "R5 write after read");
    xfer(0, 0, 0, 15, -1, "R1 reset turnaround");
    xfer(1, 0, 2, 0, -1, "R5 write after read");
    xfer(1, 0, 2, 0, -1, "R7 same-bank async writes");
    xfer(0, 0, 1, 5, -1, "R6 programmed bank2 gap");
    xfer(1, 0, 3, 0, -1, "R5 write after read");
    xfer(1, 0, 1, 15, -1, "R6 async write other bank");
    xfer(1, 1, 1, 7, -1, "R6 async write then sync write");
    xfer(1, 1, 1, 2, -1, "R9 sync writes same bank");
    xfer(1, 1, 2, 3, -1, "R10 sync writes other bank");
    xfer(0, 1, 2, 3, -1, "R10 sync write then sync read");
    xfer(1, 1, 0, 0, -1, "R5 write after read");
    xfer(0, 0, 3, 2, -1, "R11 sync write then async read");
    xfer(1, 1, 0, 0, -1, "R5 write after read");
    xfer(1, 0, 1, 2, -1, "R11 sync write then async write");

    cfgWrite(1, 4, 0, 0, 1);                    // one idle cycle spent
    xfer(1, 0, 1, 3, -1, "R7 multiplexed bank, R4 idle counted");
    xfer(1, 0, 1, 4, -1, "R7 multiplexed bank");
    cfgWrite(3, 6, 3, 0, 0);
    xfer(1, 0, 3, 3, -1, "R6 after multiplexed write");
    xfer(1, 0, 3, 0, -1, "R8 mode D without extended");
    cfgWrite(3, 6, 3, 1, 0);
    xfer(1, 0, 3, 5, -1, "R7 mode D with extended");
    cfgWrite(3, 6, 2, 1, 0);
    xfer(1, 0, 3, 0, -1, "R8 mode C with extended");

    // Lower bank3 gap to 2 during the second wait cycle.
    cfgBank = 2'd3; cfgGap = 4'd2; cfgMode = 2'd2; cfgExt = 1'b1; cfgMux = 1'b0;
    xfer(0, 0, 0, 2, 1, "R12 live configuration");

    // Stray done while idle must not restart the count.
    xfer(1, 0, 0, 0, -1, "R5 write after read");
    repeat (14) step();
    xferDone = 1'b1;
    step();
    xferDone = 1'b0;
    check(busy == 1'b0, "R3 stray done busy", int'(busy), 0);
    xfer(0, 0, 0, 0, -1, "R3 stray done ignored");

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule